// File: doc/BRIEF.md
# Multiplexed gear-code readout sequencer

This block reads an absolute multi-turn gear module over a narrow multiplexed link. It drives a 3-bit select bus and samples the 3-bit data bus that the module returns for each select value. A scan visits eight slots in a fixed order. Slot 0 returns a configuration word. Slots 1 to 7 return the 3-bit codes of gear wheels 1 to 7. The block waits a fixed settling time after every select change and only then samples the data.

A one-cycle start pulse begins a scan. The system issues it together with the single-turn encoder read, so the gear snapshot and the fine position belong to the same moment. When the last slot has been sampled, the block publishes the 21-bit gear word and the decoded configuration flags in a single cycle and pulses done. Between scans the outputs hold the last snapshot and the select bus rests at 0.

Top module: `gear_scan_seq`

## Requirements
- R1: While reset is held and after it is released: sel is 0, busy and done are 0, gears is all zeros, and cfg_14bit, cfg_solid and cfg_error are 0.
- R2: A start seen at a clock edge while idle raises busy from that edge on and begins the scan with sel = 0.
- R3: During a scan, sel steps through 0, 1, 2, ... 7 in order, and each value is driven for exactly SETTLE_CYC clock cycles.
- R4: SETTLE_CYC is CLK_HZ × SETTLE_NS / 10^9, rounded up to a whole cycle. For example, 100 MHz and 195 ns give 20 cycles.
- R5: Each slot's data is sampled on its last cycle, so it is read only after it has been stable for the full settle time. The code of gear k (k = 1..7) lands in gears[3k-1:3k-3].
- R6: Data bit 1 of the slot-0 word is reported as cfg_14bit (1 = 14-bit counter, 0 = 12-bit). Data bit 0 of that word is reported as cfg_solid.
- R7: cfg_error is 1 after a scan whose slot-0 data bit 2 read 0. It is 0 after a scan where that bit read 1. The value holds until the next scan completes.
- R8: gears and the configuration flags change only on the cycle done is high. done is a one-cycle pulse, issued once per scan, 8 × SETTLE_CYC cycles after the start edge.
- R9: A start that arrives while busy is 1 has no effect. The scan in progress keeps its timing and produces exactly one done.
- R10: When the scan completes, busy falls and sel returns to 0 together with the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Scan request pulse |
| dat | input | 3 | Data returned by the gear module for the current select |
| sel | output | 3 | Slot select toward the gear module |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse: a new snapshot is on the outputs |
| gears | output | 21 | Gear codes, gear k in bits 3k-1..3k-3 |
| cfg_14bit | output | 1 | 1 when the module reports a 14-bit revolution count |
| cfg_solid | output | 1 | Solid-shaft flag from the configuration word |
| cfg_error | output | 1 | Fixed-one configuration bit read as 0 |

## Verification
The assertions assume that start and dat change only between clock edges. They also assume that reset is held across at least one edge, so the $stable checks start from reset values. The bench drives every input on the falling edge. Its model of the gear module returns the complement of the true value until the select has been stable for all but the last cycle of a slot. A design that samples early therefore picks up wrong codes. The stimulus uses a non-integer settle time so the bench can check the rounding.

// File: rtl/gear_scan_seq.sv
module gear_scan_seq #(
  parameter longint unsigned CLK_HZ    = 50_000_000,
  parameter longint unsigned SETTLE_NS = 64_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  dat,
  output logic [2:0]  sel,
  output logic        busy,
  output logic        done,
  output logic [20:0] gears,
  output logic        cfg_14bit,
  output logic        cfg_solid,
  output logic        cfg_error
);

  localparam longint unsigned CYC_L = (CLK_HZ * SETTLE_NS + 64'd999_999_999) / 64'd1_000_000_000;
  localparam int SETTLE_CYC = (CYC_L < 1) ? 1 : int'(CYC_L);
  localparam int CW = $clog2(SETTLE_CYC + 1);

  logic          busy_q, done_q, c14_q, solid_q, err_q;
  logic [2:0]    slot_q, cfg_q;
  logic [CW-1:0] cnt_q;
  logic [17:0]   shadow_q;
  logic [20:0]   gears_q;
  logic          last;

  assign last      = (cnt_q == CW'(SETTLE_CYC - 1));
  assign sel       = slot_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign gears     = gears_q;
  assign cfg_14bit = c14_q;
  assign cfg_solid = solid_q;
  assign cfg_error = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      slot_q   <= 3'd0;
      cnt_q    <= '0;
      cfg_q    <= 3'd0;
      shadow_q <= '0;
      gears_q  <= '0;
      c14_q    <= 1'b0;
      solid_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          slot_q <= 3'd0;
          cnt_q  <= '0;
        end
      end else if (!last) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
        if (slot_q == 3'd0)
          cfg_q <= dat;
        else if (slot_q != 3'd7)
          shadow_q[3*(int'(slot_q)-1) +: 3] <= dat;
        if (slot_q == 3'd7) begin
          gears_q <= {dat, shadow_q};
          c14_q   <= cfg_q[1];
          solid_q <= cfg_q[0];
          err_q   <= ~cfg_q[2];
          done_q  <= 1'b1;
          busy_q  <= 1'b0;
          slot_q  <= 3'd0;
        end else begin
          slot_q <= slot_q + 3'd1;
        end
      end
    end
  end

  p_sel_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$stable(sel)) |-> (sel == $past(sel) + 3'd1));

  p_sel_settle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel) |-> (cnt_q == '0));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(gears) && $stable(cfg_error) && $stable(cfg_14bit) && $stable(cfg_solid)));

  p_idle_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sel == 3'd0));

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last) |=> (busy && $stable(sel)));

endmodule

// File: tb/gear_scan_seq_test.sv
module gear_scan_seq_test;
  localparam int SETTLE = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] dat, sel;
  logic busy, done, cfg_14bit, cfg_solid, cfg_error;
  logic [20:0] gears;

  int n_chk = 0;
  int n_bad = 0;

  logic [20:0] model_g = '0;
  logic [2:0]  model_cfg = 3'b100;
  logic [2:0]  last_sel = 3'd0;
  int          age = 0;
  logic [2:0]  truth;

  always #5 clk = ~clk;

  gear_scan_seq #(.CLK_HZ(100_000_000), .SETTLE_NS(195)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dat(dat), .sel(sel),
    .busy(busy), .done(done), .gears(gears), .cfg_14bit(cfg_14bit),
    .cfg_solid(cfg_solid), .cfg_error(cfg_error));

  always @(posedge clk) begin
    if (sel != last_sel) age <= 0;
    else age <= age + 1;
    last_sel <= sel;
  end

  always_comb begin
    if (sel == 3'd0) truth = model_cfg;
    else truth = model_g[3*(int'(sel)-1) +: 3];
    dat = ((sel == last_sel) && (age >= SETTLE - 2)) ? truth : ~truth;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Runs one scan. Checks the sel sequence, the done timing and the published outputs.
  task automatic run_scan(input logic [20:0] g, input logic [2:0] cfg, input bit extra_start);
    int n;
    int dones;
    logic [20:0] prev_g;
    prev_g = gears;
    model_g = g;
    model_cfg = cfg;
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy", busy, 1);
    n = 0;
    dones = 0;
    while (!done && n < 400) begin
      chk("R3 sel order", sel, 32'(n / SETTLE));
      if (n == 4 * SETTLE + 3) chk("R8 gears held mid-scan", gears, prev_g);
      if (extra_start && n == 3 * SETTLE + 5) start = 1'b1;
      if (extra_start && n == 3 * SETTLE + 7) start = 1'b0;
      @(negedge clk);
      n++;
    end
    chk("R4 R8 scan length", n, 8 * SETTLE);
    chk("R5 gears", gears, g);
    chk("R6 cfg_14bit", cfg_14bit, cfg[1]);
    chk("R6 cfg_solid", cfg_solid, cfg[0]);
    chk("R7 cfg_error", cfg_error, !cfg[2]);
    chk("R10 sel back to 0", sel, 0);
    chk("R10 busy low", busy, 0);
    for (int i = 0; i < 3 * SETTLE; i++) begin
      @(negedge clk);
      if (done) dones++;
    end
    chk("R8 done one cycle", dones, 0);
    chk("R9 idle after one scan", busy, 0);
    chk("R8 outputs held after scan", gears, g);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    chk("R1 sel", sel, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 gears", gears, 0);
    chk("R1 flags", {cfg_14bit, cfg_solid, cfg_error}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 after release sel", sel, 0);
    chk("R1 after release busy", busy, 0);
  endtask

  task automatic test_error_hold();
    int n;
    run_scan(21'h0ABCDE, 3'b011, 1'b0);
    chk("R7 error raised", cfg_error, 1);
    model_cfg = 3'b110;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 400) begin
      if (n == 5 * SETTLE) chk("R7 error held until scan end", cfg_error, 1);
      @(negedge clk);
      n++;
    end
    chk("R7 error cleared", cfg_error, 0);
    chk("R6 14bit after second scan", cfg_14bit, 1);
  endtask

  initial begin
    fork
      begin
        test_reset();
        run_scan(21'b111_110_101_100_011_010_001, 3'b111, 1'b0);
        run_scan(21'h155555, 3'b100, 1'b0);
        run_scan(21'h0F0F0F, 3'b101, 1'b1);
        test_error_hold();
      end
      begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule